// File: doc/BRIEF.md
# Rolling-Shutter Row Sequencer

This block paces the readout of a pixel array that is read one row at a time, with a correlated double sample taken inside each pixel. Each line takes a fixed slot of sixteen clocks. Inside that slot the block drives a set of phase strobes in a fixed order: a sample window, a pixel reset, a clamp, a calibration sample and, last, a discriminator latch. After the last line of a frame it starts the next frame at once, with no gap.

Two frame lengths are available. In pixel-only mode a frame holds the `ROWS` pixel lines. In pattern mode the same pixel lines are followed by two extra lines that carry a fixed test pattern instead of pixel data. The mode input is taken only when a frame begins. An external start input forces a new frame on the next clock, so several chips that receive the same start pulse run in step. After reset the block stays idle until the first start.

Top module: `row_strobe_sequencer`

## Requirements
- R1: Every line lasts exactly 16 clocks. The row index stays constant for the whole line and increases by one at the line boundary.
- R2: Phase cycles are counted 1 to 16 within a line. `rd_smp` is high in cycles 1–4, `px_rst` in 5–9, `clamp` in 10–14, `cal_smp` in cycle 15 and `latch` in cycle 16. On each running cycle exactly one of these strobes is high. `row_sel` is high on all 16 cycles of every pixel line.
- R3: With `mode`=0 a frame is lines 0 to ROWS-1. The first cycle of line 0 of the next frame follows the last cycle of line ROWS-1 directly.
- R4: With `mode`=1 a frame is ROWS+2 lines. On lines ROWS and ROWS+1, `pattern_line` is high and `row_sel` is low, and the phase strobes run exactly as on a pixel line. `pattern_line` is low on every pixel line.
- R5: `frame_start` is high for exactly one clock, on cycle 1 of line 0 of every frame, and is low at all other times.
- R6: `mode` is sampled only on the clock edge that begins a frame (a start edge or the edge that ends the last cycle of a frame). A change of `mode` in the middle of a frame alters only the next frame.
- R7: After reset, and for as long as no start is seen, `row_idx` is 0 and every strobe and flag output is low, whatever `mode` does.
- R8: A high `start` at a clock edge makes the next cycle cycle 1 of line 0 of a new frame, with `mode` sampled at that edge. This holds mid-line, mid-frame and on the last cycle of a frame, where start takes priority over the normal wrap.
- R9: An active-low `rst_n` returns the block to the idle state of R7 immediately, from any point in a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame alignment; high at an edge begins a new frame |
| mode | input | 1 | 0: pixel lines only, 1: pixel lines plus two pattern lines |
| row_idx | output | $clog2(ROWS+2) | Current line number within the frame |
| row_sel | output | 1 | Row select for the current pixel line |
| rd_smp | output | 1 | Read-sample phase strobe |
| px_rst | output | 1 | Pixel reset phase strobe |
| clamp | output | 1 | Clamp phase strobe |
| cal_smp | output | 1 | Calibration-sample phase strobe |
| latch | output | 1 | Discriminator latch strobe |
| line_valid | output | 1 | High while a line is being sequenced |
| pattern_line | output | 1 | High on the appended pattern lines |
| frame_start | output | 1 | One-clock pulse at the first cycle of each frame |

## Verification
The case that needs care is an external start that arrives on the last cycle of a frame, on the same edge where the line counter would wrap by itself. It also matters when `mode` changes on that same edge. The bench pulses start exactly on that final cycle with the other mode value. It then checks that the next frame opens at line 0 with a single `frame_start`, and that its length follows the mode taken at the start edge. A separate run changes `mode` in the middle of a frame and confirms that the running frame keeps its length and only the following frame changes.

// File: rtl/row_strobe_sequencer.sv
module row_strobe_sequencer #(
  parameter int ROWS      = 576,
  parameter int PAT_LINES = 2,
  parameter int RD_LEN    = 4,
  parameter int RST_LEN   = 5,
  parameter int CLP_LEN   = 5,
  localparam int PHASES    = RD_LEN + RST_LEN + CLP_LEN + 2,
  localparam int LINES_MAX = ROWS + PAT_LINES,
  localparam int LW        = $clog2(LINES_MAX),
  localparam int CW        = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  output logic [LW-1:0] row_idx,
  output logic          row_sel,
  output logic          rd_smp,
  output logic          px_rst,
  output logic          clamp,
  output logic          cal_smp,
  output logic          latch,
  output logic          line_valid,
  output logic          pattern_line,
  output logic          frame_start
);

  localparam int RST_BEG = RD_LEN;
  localparam int CLP_BEG = RD_LEN + RST_LEN;
  localparam int CAL_CYC = CLP_BEG + CLP_LEN;
  localparam int LAT_CYC = CAL_CYC + 1;

  logic          run;
  logic          mode_q;
  logic [LW-1:0] line;
  logic [CW-1:0] cyc;

  wire           last_cyc  = (int'(cyc) == LAT_CYC);
  wire [LW-1:0]  last_line = mode_q ? LW'(LINES_MAX - 1) : LW'(ROWS - 1);
  wire           at_end    = (line == last_line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      mode_q <= 1'b0;
      line   <= '0;
      cyc    <= '0;
    end else if (start) begin
      run    <= 1'b1;
      mode_q <= mode;
      line   <= '0;
      cyc    <= '0;
    end else if (run) begin
      if (last_cyc) begin
        cyc <= '0;
        if (at_end) begin
          line   <= '0;
          mode_q <= mode;
        end else begin
          line <= line + 1'b1;
        end
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end

  wire on_pattern = int'(line) >= ROWS;

  assign row_idx      = line;
  assign line_valid   = run;
  assign pattern_line = run && on_pattern;
  assign row_sel      = run && !on_pattern;
  assign rd_smp       = run && (int'(cyc) <  RST_BEG);
  assign px_rst       = run && (int'(cyc) >= RST_BEG) && (int'(cyc) < CLP_BEG);
  assign clamp        = run && (int'(cyc) >= CLP_BEG) && (int'(cyc) < CAL_CYC);
  assign cal_smp      = run && (int'(cyc) == CAL_CYC);
  assign latch        = run && last_cyc;
  assign frame_start  = run && (line == '0) && (cyc == '0);

  assert_row_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && !start && !at_end) |=> (row_idx == LW'($past(row_idx) + 1'b1)));

  assert_one_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> ($countones({rd_smp, px_rst, clamp, cal_smp, latch}) == 1));

  assert_pattern_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pattern_line |-> (mode_q && !row_sel));

  assert_frame_start_line0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (row_idx == '0 && rd_smp));

  assert_frame_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !start) |=> !frame_start);

  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |-> $stable(mode_q));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_valid && !start) |=> (!line_valid && row_idx == '0 && !latch && !frame_start));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (frame_start && row_idx == '0));

endmodule

// File: tb/tb_row_strobe_sequencer.sv
`timescale 1ns/1ps
module tb_row_strobe_sequencer;
  localparam int ROWS = 4;
  localparam int LW   = $clog2(ROWS + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic [LW-1:0] row_idx;
  logic row_sel, rd_smp, px_rst, clamp, cal_smp, latch;
  logic line_valid, pattern_line, frame_start;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  row_strobe_sequencer #(.ROWS(ROWS)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .row_idx(row_idx), .row_sel(row_sel), .rd_smp(rd_smp), .px_rst(px_rst),
    .clamp(clamp), .cal_smp(cal_smp), .latch(latch), .line_valid(line_valid),
    .pattern_line(pattern_line), .frame_start(frame_start)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, "row_idx", int'(row_idx), 0);
    chk(req, "strobes", int'({row_sel, rd_smp, px_rst, clamp, cal_smp, latch}), 0);
    chk(req, "flags", int'({line_valid, pattern_line, frame_start}), 0);
  endtask

  // k cycles after frame start; first frame l0 lines, following frames l1 lines
  task automatic chk_run(input string tag, input int k, input int l0, input int l1);
    int loc, ln, c;
    loc = (k < l0 * 16) ? k : (k - l0 * 16) % (l1 * 16);
    ln  = loc / 16;
    c   = loc % 16 + 1;
    chk(tag, "row_idx", int'(row_idx), ln);
    chk("R1", "line_valid", int'(line_valid), 1);
    chk("R4", "pattern_line", int'(pattern_line), int'(ln >= ROWS));
    chk("R4", "row_sel", int'(row_sel), int'(ln < ROWS));
    chk("R2", "rd_smp", int'(rd_smp), int'(c <= 4));
    chk("R2", "px_rst", int'(px_rst), int'(c >= 5 && c <= 9));
    chk("R2", "clamp", int'(clamp), int'(c >= 10 && c <= 14));
    chk("R2", "cal_smp", int'(cal_smp), int'(c == 15));
    chk("R2", "latch", int'(latch), int'(c == 16));
    chk("R5", "frame_start", int'(frame_start), int'(ln == 0 && c == 1));
  endtask

  task automatic go(input logic m);
    start = 1'b1;
    mode  = m;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_seg(input string tag, input int l0, input int l1, input int n,
                         input int chg_at, input logic chg_val);
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      chk_run(tag, i, l0, l1);
      if (i == chg_at) mode = chg_val;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R9");
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk_idle("R7");
      mode = ~mode;
    end
    go(1'b0);
    run_seg("R3", 4, 4, 3 * 64, -1, 1'b0);
    go(1'b1);
    run_seg("R4", 6, 6, 2 * 96, -1, 1'b1);
    go(1'b1);
    run_seg("R6", 6, 4, 96 + 64 + 10, 20, 1'b0);
    go(1'b0);
    run_seg("R3", 4, 4, 64, -1, 1'b0);
    go(1'b1);
    run_seg("R8", 6, 6, 40, -1, 1'b1);
    go(1'b0);
    run_seg("R8", 4, 4, 20, -1, 1'b0);
    rst_n = 1'b0;
    #1;
    chk_idle("R9");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk_idle("R9");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired at %0t: actual 0 expected 1", $time);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule